// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. It holds an accumulator register and a five-bit status register (carry, auxiliary carry, zero, sign, parity). On each clock where the write enable is high, it applies one operation to the accumulator, an operand byte and the stored carry. The operation is chosen by a 4-bit code. The new accumulator value and the new flags are both registered, so the results appear on the outputs one cycle after the request.

The operations are binary add and subtract, each with and without the stored carry; a compare that changes only the flags; bitwise AND, OR and XOR; a one's complement; four rotates; and a decimal correction step used after adding two packed BCD bytes. A surrounding core supplies the operand byte, which may come from a register or an immediate, and a code it has already decoded. Instruction fetch, opcode decoding and register selection belong to that core.

Top module: `acc_alu_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and all five flags to 0 on the next clock edge.
- R2: When the write enable is low, or when the code is 14 or 15 (unused), the accumulator and all flags keep their values.
- R3: Code 0 (add) and code 1 (add plus stored carry) write the 8-bit sum to the accumulator. Carry becomes the carry out of bit 7, and auxiliary carry becomes the carry out of bit 3.
- R4: Code 2 (subtract) and code 3 (subtract minus stored carry) write accumulator minus operand (minus carry for code 3), modulo 256. Carry is set when the operand (plus the borrow-in) exceeds the accumulator as unsigned numbers. Auxiliary carry is set when the low nibble of the operand (plus the borrow-in) exceeds the low nibble of the accumulator.
- R5: Code 4 (compare) sets carry, auxiliary carry, zero, sign and parity exactly as code 2 would, but the accumulator keeps its old value.
- R6: Codes 5, 6 and 7 write the bitwise AND, OR and XOR of accumulator and operand. Each clears both carry and auxiliary carry. XOR of the accumulator with itself leaves zero in the accumulator and sets the zero flag.
- R7: After codes 0 to 7 and code 13, zero is set exactly when the result byte is 0, sign equals bit 7 of the result, and parity is 1 when the result has an even number of one bits. For code 4, the result byte is the difference.
- R8: Code 8 inverts all eight accumulator bits and leaves all five flags unchanged.
- R9: Code 9 rotates left, copying bit 7 into both bit 0 and carry. Code 10 rotates right, copying bit 0 into both bit 7 and carry.
- R10: Code 11 rotates left through carry: bit 7 goes to carry and the old carry goes to bit 0. Code 12 rotates right through carry: bit 0 goes to carry and the old carry goes to bit 7.
- R11: The four rotate codes (9 to 12) change only the accumulator and carry. Auxiliary carry, zero, sign and parity keep their values.
- R12: Code 13 (decimal correct) first adds 6 if the low nibble is above 9 or auxiliary carry is set. Auxiliary carry becomes the carry out of the low nibble from that addition. It then adds 0x60 if carry is set, if that first addition carried past bit 7, or if the upper nibble is then above 9. Carry ends up set exactly when this second addition is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Apply the selected operation on this edge |
| op_code | input | 4 | Operation code, 0 to 13 (14 and 15 unused) |
| operand | input | 8 | Second operand byte |
| acc_o | output | 8 | Registered accumulator |
| cy_o | output | 1 | Carry / borrow flag |
| ac_o | output | 1 | Auxiliary (nibble) carry flag |
| z_o | output | 1 | Zero flag |
| s_o | output | 1 | Sign flag |
| p_o | output | 1 | Parity flag (1 = even count of ones) |

## Verification
The assertions assume that the code and operand are stable when the clock rises, and that reset is held for at least one edge before any checked operation. The write-only and reserved-code properties assume nothing about the operand, so the stimulus drives arbitrary operand bytes even with the enable low. The bench changes inputs only on falling edges, so every request is settled before it is sampled. Its random section uses the full 0 to 15 code range, which places reserved codes and idle cycles between real operations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int DW = 8;
  localparam int NW = 4;
  localparam int CW = 4;

  typedef enum logic [CW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_CMA = 4'd8,
    OP_RLC = 4'd9,
    OP_RRC = 4'd10,
    OP_RAL = 4'd11,
    OP_RAR = 4'd12,
    OP_DAA = 4'd13
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W  = acc_alu_pkg::DW,
  parameter int NW = acc_alu_pkg::NW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         hout
);

  logic [W-1:0]  b_eff;
  logic          c_eff;
  logic [W:0]    full;
  logic [NW:0]   half;

  // subtraction as a + ~b + ~borrow_in; borrow is the inverted carry
  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    half  = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
    res   = full[W-1:0];
    cout  = sub ? ~full[W] : full[W];
    hout  = sub ? ~half[NW] : half[NW];
  end

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int W = acc_alu_pkg::DW
) (
  input  logic [CW-1:0] op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);

  always_comb begin
    res  = a;
    cout = cin;
    case (op)
      OP_AND: begin res = a & b; cout = 1'b0; end
      OP_OR:  begin res = a | b; cout = 1'b0; end
      OP_XOR: begin res = a ^ b; cout = 1'b0; end
      OP_CMA: begin res = ~a;    cout = cin;  end
      OP_RLC: begin res = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
      OP_RRC: begin res = {a[0], a[W-1:1]};   cout = a[0];   end
      OP_RAL: begin res = {a[W-2:0], cin};    cout = a[W-1]; end
      OP_RAR: begin res = {cin, a[W-1:1]};    cout = a[0];   end
      default: begin res = a; cout = cin; end
    endcase
  end

endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
  parameter int W  = acc_alu_pkg::DW,
  parameter int NW = acc_alu_pkg::NW
) (
  input  logic [W-1:0] a,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic [W-1:0] res,
  output logic         cy_out,
  output logic         ac_out
);

  localparam logic [W:0]   LO_STEP = (W+1)'(6);
  localparam logic [W-1:0] HI_STEP = W'(96);
  localparam logic [NW-1:0] DIGMAX = NW'(9);

  logic       lo_fix;
  logic       hi_fix;
  logic [W:0] stage1;

  always_comb begin
    lo_fix = ac_in || (a[NW-1:0] > DIGMAX);
    stage1 = {1'b0, a} + (lo_fix ? LO_STEP : '0);
    ac_out = lo_fix && (a[NW-1:0] > DIGMAX);
    hi_fix = cy_in || stage1[W] || (stage1[W-1:NW] > DIGMAX);
    res    = stage1[W-1:0] + (hi_fix ? HI_STEP : '0);
    cy_out = hi_fix;
  end

endmodule

// File: rtl/alu_szp.sv
module alu_szp #(
  parameter int W = acc_alu_pkg::DW
) (
  input  logic [W-1:0] val,
  output logic         zero,
  output logic         sign,
  output logic         par_even
);

  logic [W:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_par
    assign chain[i+1] = chain[i] ^ val[i];
  end

  assign zero     = (val == '0);
  assign sign     = val[W-1];
  assign par_even = ~chain[W];

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = acc_alu_pkg::DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] op_code,
  input  logic [W-1:0]  operand,
  output logic [W-1:0]  acc_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          z_o,
  output logic          s_o,
  output logic          p_o
);

  logic [W-1:0] acc_q, acc_d;
  flags_t       fl_q, fl_d;

  logic         as_cin, as_sub, as_c, as_h;
  logic [W-1:0] as_res;
  logic [W-1:0] bo_res;
  logic         bo_c;
  logic [W-1:0] da_res;
  logic         da_c, da_h;
  logic [W-1:0] szp_in;
  logic         sz_z, sz_s, sz_p;

  assign as_cin = ((op_code == OP_ADC) || (op_code == OP_SBB)) ? fl_q.cy : 1'b0;
  assign as_sub = (op_code == OP_SUB) || (op_code == OP_SBB) || (op_code == OP_CMP);

  alu_addsub #(.W(W)) u_addsub (
    .a(acc_q), .b(operand), .cin(as_cin), .sub(as_sub),
    .res(as_res), .cout(as_c), .hout(as_h)
  );

  alu_bitops #(.W(W)) u_bitops (
    .op(op_code), .a(acc_q), .b(operand), .cin(fl_q.cy),
    .res(bo_res), .cout(bo_c)
  );

  alu_decadj #(.W(W)) u_decadj (
    .a(acc_q), .cy_in(fl_q.cy), .ac_in(fl_q.ac),
    .res(da_res), .cy_out(da_c), .ac_out(da_h)
  );

  always_comb begin
    case (op_code)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: szp_in = as_res;
      OP_AND, OP_OR, OP_XOR:                  szp_in = bo_res;
      OP_DAA:                                 szp_in = da_res;
      default:                                szp_in = acc_q;
    endcase
  end

  alu_szp #(.W(W)) u_szp (
    .val(szp_in), .zero(sz_z), .sign(sz_s), .par_even(sz_p)
  );

  always_comb begin
    acc_d = acc_q;
    fl_d  = fl_q;
    case (op_code)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        acc_d   = as_res;
        fl_d.cy = as_c;
        fl_d.ac = as_h;
        fl_d.z  = sz_z;
        fl_d.s  = sz_s;
        fl_d.p  = sz_p;
      end
      OP_CMP: begin
        fl_d.cy = as_c;
        fl_d.ac = as_h;
        fl_d.z  = sz_z;
        fl_d.s  = sz_s;
        fl_d.p  = sz_p;
      end
      OP_AND, OP_OR, OP_XOR: begin
        acc_d   = bo_res;
        fl_d.cy = bo_c;
        fl_d.ac = 1'b0;
        fl_d.z  = sz_z;
        fl_d.s  = sz_s;
        fl_d.p  = sz_p;
      end
      OP_CMA, OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        acc_d   = bo_res;
        fl_d.cy = bo_c;
      end
      OP_DAA: begin
        acc_d   = da_res;
        fl_d.cy = da_c;
        fl_d.ac = da_h;
        fl_d.z  = sz_z;
        fl_d.s  = sz_s;
        fl_d.p  = sz_p;
      end
      default: begin
        acc_d = acc_q;
        fl_d  = fl_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fl_q  <= '0;
    end else if (wr_en) begin
      acc_q <= acc_d;
      fl_q  <= fl_d;
    end
  end

  assign acc_o = acc_q;
  assign cy_o  = fl_q.cy;
  assign ac_o  = fl_q.ac;
  assign z_o   = fl_q.z;
  assign s_o   = fl_q.s;
  assign p_o   = fl_q.p;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = acc_alu_pkg::DW
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [3:0]   op_code,
  input logic [W-1:0] acc_o,
  input logic         cy_o,
  input logic         ac_o,
  input logic         z_o,
  input logic         s_o,
  input logic         p_o
);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && !cy_o && !ac_o && !z_o && !s_o && !p_o));

  // R2
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || op_code > 4'd13) |=>
      ($stable(acc_o) && $stable(cy_o) && $stable(ac_o) &&
       $stable(z_o) && $stable(s_o) && $stable(p_o)));

  // R5
  a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code == 4'd4) |=> $stable(acc_o));

  // R6
  a_r6_logic_clears_carries: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code inside {4'd5, 4'd6, 4'd7}) |=> (!cy_o && !ac_o));

  // R7
  a_r7_result_flags: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd13}) |=>
      (z_o == (acc_o == '0) && s_o == acc_o[W-1] && p_o == ~^acc_o));

  // R8
  a_r8_complement: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code == 4'd8) |=>
      (acc_o == ~$past(acc_o) && $stable(cy_o) && $stable(ac_o) &&
       $stable(z_o) && $stable(s_o) && $stable(p_o)));

  // R9
  a_r9_rotate_left: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code == 4'd9) |=>
      (acc_o == {$past(acc_o[W-2:0]), $past(acc_o[W-1])} && cy_o == $past(acc_o[W-1])));

  // R10
  a_r10_rotate_right_carry: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code == 4'd12) |=>
      (acc_o == {$past(cy_o), $past(acc_o[W-1:1])} && cy_o == $past(acc_o[0])));

  // R11
  a_r11_rotate_flags: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code inside {4'd9, 4'd10, 4'd11, 4'd12}) |=>
      ($stable(ac_o) && $stable(z_o) && $stable(s_o) && $stable(p_o)));

endmodule

bind acc_alu_core acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .op_code(op_code),
  .acc_o(acc_o), .cy_o(cy_o), .ac_o(ac_o), .z_o(z_o), .s_o(s_o), .p_o(p_o)
);

// File: tb/tb_acc_alu_core.sv
module tb_acc_alu_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc_o;
  logic       cy_o, ac_o, z_o, s_o, p_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  int m_acc = 0, m_cy = 0, m_ac = 0, m_z = 0, m_s = 0, m_p = 0;

  always #5 clk = ~clk;

  acc_alu_core dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .op_code(op_code), .operand(operand),
    .acc_o(acc_o), .cy_o(cy_o), .ac_o(ac_o), .z_o(z_o), .s_o(s_o), .p_o(p_o)
  );

  function automatic void set_szp(int v);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (((v >> i) & 1) == 1) ones++;
    m_z = (v == 0) ? 1 : 0;
    m_s = (v >> 7) & 1;
    m_p = (ones % 2 == 0) ? 1 : 0;
  endfunction

  function automatic void model(int op, int b, bit we);
    int r, c, lo, t;
    if (!we || op > 13) return;
    case (op)
      0, 1: begin
        c = (op == 1) ? m_cy : 0;
        r = m_acc + b + c;
        m_ac = ((m_acc & 15) + (b & 15) + c > 15) ? 1 : 0;
        m_cy = (r > 255) ? 1 : 0;
        m_acc = r & 255;
        set_szp(m_acc);
      end
      2, 3, 4: begin
        c = (op == 3) ? m_cy : 0;
        r = m_acc - b - c;
        m_ac = ((m_acc & 15) - (b & 15) - c < 0) ? 1 : 0;
        m_cy = (r < 0) ? 1 : 0;
        set_szp(r & 255);
        if (op != 4) m_acc = r & 255;
      end
      5, 6, 7: begin
        if (op == 5) m_acc = m_acc & b;
        else if (op == 6) m_acc = m_acc | b;
        else m_acc = m_acc ^ b;
        m_cy = 0; m_ac = 0;
        set_szp(m_acc);
      end
      8: m_acc = (~m_acc) & 255;
      9: begin c = m_acc >> 7; m_acc = ((m_acc << 1) & 255) | c; m_cy = c; end
      10: begin c = m_acc & 1; m_acc = (m_acc >> 1) | (c << 7); m_cy = c; end
      11: begin c = m_acc >> 7; m_acc = ((m_acc << 1) & 255) | m_cy; m_cy = c; end
      12: begin c = m_acc & 1; m_acc = (m_acc >> 1) | (m_cy << 7); m_cy = c; end
      default: begin
        lo = m_acc & 15;
        t = m_acc;
        if (lo > 9 || m_ac == 1) begin t = t + 6; m_ac = (lo > 9) ? 1 : 0; end
        else m_ac = 0;
        if (t > 255 || ((t >> 4) & 15) > 9 || m_cy == 1) begin t = t + 96; m_cy = 1; end
        m_acc = t & 255;
        set_szp(m_acc);
      end
    endcase
  endfunction

  function automatic string tag_of(int o, bit we);
    if (!we) return "R2";
    case (o)
      0, 1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5, 6, 7: return "R6";
      8: return "R8";
      9, 10: return "R9";
      11, 12: return "R10";
      13: return "R12";
      default: return "R2";
    endcase
  endfunction

  task automatic compare(string tag);
    logic [12:0] got, exp;
    got = {acc_o, cy_o, ac_o, z_o, s_o, p_o};
    exp = {8'(m_acc), 1'(m_cy), 1'(m_ac), 1'(m_z), 1'(m_s), 1'(m_p)};
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got acc=%h cy=%b ac=%b z=%b s=%b p=%b, expected acc=%h cy=%b ac=%b z=%b s=%b p=%b",
               tag, got[12:5], got[4], got[3], got[2], got[1], got[0],
               exp[12:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  // called at a falling edge; result checked at the next falling edge
  task automatic step(int op, int b, bit we, string tag);
    op_code = 4'(op);
    operand = 8'(b);
    wr_en   = we;
    model(op, b, we);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_acc = 0; m_cy = 0; m_ac = 0; m_z = 0; m_s = 0; m_p = 0;
    compare("R1");
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R6 load via OR from zero
    step(6, 8'h3C, 1, "R6");
    // R3 add to exactly 0x100: zero result, carry and nibble carry
    step(0, 8'hC4, 1, "R3");
    compare("R7");
    step(1, 8'h05, 1, "R3");
    // R4 borrow cases
    step(2, 8'h07, 1, "R4");
    step(3, 8'h00, 1, "R4");
    // R5 compare equal and greater
    step(4, 8'hFE, 1, "R5");
    step(4, 8'hFF, 1, "R5");
    // R8 complement keeps flags
    step(8, 8'h00, 1, "R8");
    // R9 / R10 / R11 rotates
    step(6, 8'h81, 1, "R6");
    step(9, 8'h00, 1, "R9");
    step(10, 8'h00, 1, "R9");
    step(10, 8'h00, 1, "R9");
    step(11, 8'h00, 1, "R10");
    step(12, 8'h00, 1, "R10");
    step(12, 8'h00, 1, "R11");
    // R6 XOR with itself
    step(7, m_acc, 1, "R6");
    step(5, 8'hAA, 1, "R6");
    // R12 decimal correction: 38+45 -> 83
    step(6, 8'h38, 1, "R6");
    step(0, 8'h45, 1, "R3");
    step(13, 8'h00, 1, "R12");
    // 99+01 -> 00 with carry
    step(7, m_acc, 1, "R6");
    step(6, 8'h99, 1, "R6");
    step(0, 8'h01, 1, "R3");
    step(13, 8'h00, 1, "R12");
    // 09+09 -> 18 via nibble carry
    step(7, m_acc, 1, "R6");
    step(6, 8'h09, 1, "R6");
    step(0, 8'h09, 1, "R3");
    step(13, 8'h00, 1, "R12");
    compare("R7");
    // R2 idle and unused codes
    step(0, 8'h55, 0, "R2");
    step(14, 8'h12, 1, "R2");
    step(15, 8'hFF, 1, "R2");
    // mid-run reset
    @(negedge clk);
    do_reset();

    for (int i = 0; i < 600; i++) begin
      int o = $urandom_range(0, 15);
      int v = $urandom_range(0, 255);
      bit we = ($urandom_range(0, 3) != 0);
      step(o, v, we, tag_of(o, we));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule